// File: doc/BRIEF.md
# Channel Status Shadow Bank

This block stores the 40-bit consumer channel status word of an IEC 60958 audio stream in two register sets. Software fills a writable working set one byte at a time. The serial datapath reads only from a shadow set, which software can read but cannot write. Once the working bytes are in place, software raises a reload request in a control register. The bank then copies all five working bytes into the shadow set in one clock edge, at the next channel status block start. A 192-frame block therefore never mixes old and new status.

The block also keeps the frame index within the current block. A block-start pulse forces the index to frame 0, and a per-frame strobe moves it forward. The serial channel status bit for the current frame is taken from the shadow set. The register port is a plain address/write-enable/data interface with a combinational read path.

Top module: `chanStatusBank`

## Requirements
- R1: After reset, every working byte, every shadow byte and the control register read 0x00, the frame index is 0, and `csBit` is 0.
- R2: Addresses 1 to 5 hold working bytes 0 to 4 and read back what was last written. Addresses 6 to 10 read shadow bytes 0 to 4. Writes to addresses 6 to 10 are ignored, and shadow bytes do not change when working bytes are written.
- R3: Address 0 is the control register. Writing 1 to bit 0 marks a reload as pending, and bit 0 reads 1 while a reload is pending. Bits 7:1 always read 0. Writing 0 to bit 0 does not cancel a pending reload.
- R4: On the first clock edge where `blockStart` is high and a reload is pending, all five shadow bytes take the working values, and the pending bit clears on that same edge. A `blockStart` with no reload pending leaves the shadow bytes unchanged, and a pending reload waits through frame strobes until a block start arrives.
- R5: If a working-byte write lands in the same cycle as a committing `blockStart`, the newly written value goes into the shadow copy. If a reload set lands on a committing edge, it is absorbed and the bit reads 0 afterwards. If a reload set lands on a `blockStart` edge with nothing pending, the bit stays pending until the next block start.
- R6: For frame index n below 40, `csBit` equals shadow bit n, which is bit n mod 8 of shadow byte n/8. For frames 40 to 191, `csBit` is 0.
- R7: `blockStart` sets the frame index to 0 on its edge, whatever the current frame. `frameStrobe` alone advances the index by one, and the index wraps from 191 to 0.
- R8: The stored byte 0 is sent with its bit 0 first: bit 0 marks professional (1) or consumer (0), bit 1 marks non-linear (1) or linear PCM (0), bit 2 at 0 means copyright is asserted, bits 5:3 hold the emphasis code, and bits 7:6 hold the mode (00 = mode 0). Each of these bits shows on `csBit` in frames 0 to 7 in that order.
- R9: Writes to addresses 11 to 15 change no register, and reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write enable for the register port |
| regWrData | input | 8 | Data to write |
| regRdData | output | 8 | Read data at `regAddr` (combinational) |
| frameStrobe | input | 1 | One-cycle pulse per audio frame |
| blockStart | input | 1 | Marks frame 0 of a channel status block |
| csBit | output | 1 | Channel status bit for the current frame |

## Verification
The bench aims at the moments where a weak design would send mixed status. It writes a working byte in the same cycle as the committing block start; a design without the bypass would send the previous value for a whole block. It sets the reload request again on the commit edge and then on a block start with nothing pending; a design with the wrong priority would either commit twice or drop the request. It also writes 0 to a pending request, which must not cancel it. It walks all 192 frames and the wrap to check where each shadow bit appears and that frames 40 to 191 are zero, and it restarts the index in the middle of a block.

// File: rtl/chanStatusPkg.sv
package chanStatusPkg;
  parameter int CS_BYTES  = 5;
  parameter int BYTE_W    = 8;
  parameter int ADDR_W    = 4;
  localparam int CS_BITS   = CS_BYTES * BYTE_W;
  localparam int CTRL_ADDR = 0;
  localparam int WORK_BASE = 1;
  localparam int SHAD_BASE = WORK_BASE + CS_BYTES;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [CS_BYTES-1:0] wrWork;       // write working byte i this cycle
    logic                setReload;    // software asks for a reload
    logic                commit;       // copy working into shadow on this edge
    logic                frameAdv;     // advance frame index
    logic                frameRestart; // force frame index to 0
  } csStrobes_t;
endpackage

// File: rtl/chanStatusCtrl.sv
module chanStatusCtrl
  import chanStatusPkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FIDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              reloadBit,
  input  logic              frameStrobe,
  input  logic              blockStart,
  output csStrobes_t        strb,
  output logic              reloadPend,
  output logic [FIDX_W-1:0] frameIdx
);
  localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(FRAMES - 1);

  // address decode and event strobes
  always_comb begin
    strb = '0;
    for (int i = 0; i < CS_BYTES; i++) begin
      strb.wrWork[i] = regWrEn && (regAddr == ADDR_W'(WORK_BASE + i));
    end
    strb.setReload    = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR)) && reloadBit;
    strb.commit       = blockStart && reloadPend;
    strb.frameRestart = blockStart;
    strb.frameAdv     = frameStrobe && !blockStart;
  end

  // pending reload: the clear on commit takes priority over a new set
  always_ff @(posedge clk) begin
    if (!rstN)            reloadPend <= 1'b0;
    else if (strb.commit) reloadPend <= 1'b0;
    else if (strb.setReload) reloadPend <= 1'b1;
  end

  // frame index within the current block
  always_ff @(posedge clk) begin
    if (!rstN)                  frameIdx <= '0;
    else if (strb.frameRestart) frameIdx <= '0;
    else if (strb.frameAdv)     frameIdx <= (frameIdx == LAST_FRAME) ? '0 : frameIdx + 1'b1;
  end

  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    reloadPend && blockStart |=> !reloadPend); // R4
  AST_NO_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    reloadPend && !blockStart |=> reloadPend); // R3
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameIdx <= LAST_FRAME); // R7
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !blockStart && frameIdx == LAST_FRAME |=> frameIdx == '0); // R7
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |=> frameIdx == '0); // R7
endmodule

// File: rtl/chanStatusData.sv
module chanStatusData
  import chanStatusPkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FIDX_W = $clog2(FRAMES),
  localparam int BSEL_W = $clog2(CS_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobes_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              reloadPend,
  input  logic [FIDX_W-1:0] frameIdx,
  output logic [BYTE_W-1:0] regRdData,
  output logic              csBit
);
  logic [BYTE_W-1:0]  workQ   [CS_BYTES];
  logic [BYTE_W-1:0]  shadowQ [CS_BYTES];
  logic [CS_BITS-1:0] workBits;
  logic [CS_BITS-1:0] shadowBits;
  logic [BSEL_W-1:0]  bitSel;
  logic               inBody;

  // working set: written by software only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CS_BYTES; i++) workQ[i] <= '0;
    end else begin
      for (int i = 0; i < CS_BYTES; i++) begin
        if (strb.wrWork[i]) workQ[i] <= regWrData;
      end
    end
  end

  // shadow set: whole-word copy at a committing block start,
  // a same-cycle software write bypasses into the copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CS_BYTES; i++) shadowQ[i] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < CS_BYTES; i++) begin
        shadowQ[i] <= strb.wrWork[i] ? regWrData : workQ[i];
      end
    end
  end

  // flat views, byte i occupies bits 8i..8i+7, bit 0 sent first
  for (genvar g = 0; g < CS_BYTES; g++) begin : g_flat
    assign workBits[g*BYTE_W +: BYTE_W]   = workQ[g];
    assign shadowBits[g*BYTE_W +: BYTE_W] = shadowQ[g];
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) regRdData = {{(BYTE_W-1){1'b0}}, reloadPend};
    for (int i = 0; i < CS_BYTES; i++) begin
      if (regAddr == ADDR_W'(WORK_BASE + i)) regRdData = workQ[i];
      if (regAddr == ADDR_W'(SHAD_BASE + i)) regRdData = shadowQ[i];
    end
  end

  // serial channel status bit for the current frame
  assign inBody = (int'(frameIdx) < CS_BITS);
  assign bitSel = BSEL_W'(frameIdx);
  assign csBit  = inBody ? shadowBits[bitSel] : 1'b0;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(shadowBits)); // R4
  AST_WORK_TO_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && strb.wrWork == '0 |=> shadowBits == $past(workBits)); // R4
  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrWork == '0 |=> $stable(workBits)); // R2
endmodule

// File: rtl/chanStatusBank.sv
module chanStatusBank
  import chanStatusPkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FIDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              frameStrobe,
  input  logic              blockStart,
  output logic              csBit
);
  csStrobes_t        strb;
  logic              reloadPend;
  logic [FIDX_W-1:0] frameIdx;

  chanStatusCtrl #(.FRAMES(FRAMES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .reloadBit  (regWrData[0]),
    .frameStrobe(frameStrobe),
    .blockStart (blockStart),
    .strb       (strb),
    .reloadPend (reloadPend),
    .frameIdx   (frameIdx)
  );

  chanStatusData #(.FRAMES(FRAMES)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .reloadPend(reloadPend),
    .frameIdx  (frameIdx),
    .regRdData (regRdData),
    .csBit     (csBit)
  );
endmodule

// File: tb/test_chanStatusBank.sv
module test_chanStatusBank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       frameStrobe = 1'b0;
  logic       blockStart = 1'b0;
  logic       csBit;

  int total = 0;
  int bad = 0;
  logic [7:0] expSh [5];
  int expFrame = 0;

  chanStatusBank i_chanStatusBank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .frameStrobe(frameStrobe),
    .blockStart(blockStart), .csBit(csBit)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0] wa; logic [7:0] wd; logic [3:0] ca; logic [7:0] ce; logic isR9;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  8'h0B, 4'd1,  8'h0B, 1'b0},  // R2 working byte 0 (R8 layout)
    '{4'd2,  8'hA5, 4'd2,  8'hA5, 1'b0},  // R2
    '{4'd3,  8'h5A, 4'd3,  8'h5A, 1'b0},  // R2
    '{4'd4,  8'hFF, 4'd4,  8'hFF, 1'b0},  // R2
    '{4'd5,  8'h81, 4'd5,  8'h81, 1'b0},  // R2
    '{4'd6,  8'hEE, 4'd6,  8'h00, 1'b0},  // R2 shadow not writable
    '{4'd10, 8'h33, 4'd10, 8'h00, 1'b0},  // R2 shadow not writable
    '{4'd12, 8'h77, 4'd12, 8'h00, 1'b1},  // R9 unmapped
    '{4'd15, 8'h11, 4'd1,  8'h0B, 1'b1}   // R9 unmapped write leaves byte 0
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a; #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic blk();
    blockStart = 1'b1; tick(); blockStart = 1'b0; expFrame = 0;
  endtask

  task automatic strobe();
    frameStrobe = 1'b1; tick(); frameStrobe = 1'b0;
    expFrame = (expFrame == 191) ? 0 : expFrame + 1;
  endtask

  function automatic logic expBit(input int n);
    return (n < 40) ? expSh[n/8][n%8] : 1'b0;
  endfunction

  task automatic shadowChk(input string tag);
    for (int i = 0; i < 5; i++) rdChk(tag, 4'(6 + i), expSh[i]);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) expSh[i] = 8'h00;
    repeat (3) tick();
    // R1 reset state
    for (int a = 0; a < 16; a++) rdChk("R1", 4'(a), 8'h00);
    chk("R1 csBit", {7'b0, csBit}, 8'h00);
    rstN = 1'b1;
    tick();

    // table walk: write, read back, shadow untouched
    for (int v = 0; v < NV; v++) begin
      wr(VECS[v].wa, VECS[v].wd);
      rdChk(VECS[v].isR9 ? "R9" : "R2", VECS[v].ca, VECS[v].ce);
    end
    shadowChk("R2 shadow before commit");

    // R4 block start with nothing pending
    blk();
    shadowChk("R4 no pending");
    rdChk("R4 ctrl idle", 4'd0, 8'h00);

    // R3 set, reserved bits, no cancel
    wr(4'd0, 8'hFF);
    rdChk("R3 set", 4'd0, 8'h01);
    wr(4'd0, 8'hFE);
    rdChk("R3 no cancel", 4'd0, 8'h01);
    // R4 strobes alone do not commit
    strobe(); strobe();
    shadowChk("R4 waits for block");
    rdChk("R4 still pending", 4'd0, 8'h01);
    blk();
    expSh[0] = 8'h0B; expSh[1] = 8'hA5; expSh[2] = 8'h5A; expSh[3] = 8'hFF; expSh[4] = 8'h81;
    shadowChk("R4 commit");
    rdChk("R4 clear", 4'd0, 8'h00);

    // R8 byte 0 layout: professional, non-linear, copyright, emphasis 001
    chk("R8 professional", {7'b0, csBit}, 8'h01);
    strobe(); chk("R8 non-linear", {7'b0, csBit}, 8'h01);
    strobe(); chk("R8 copyright asserted", {7'b0, csBit}, 8'h00);
    strobe(); chk("R8 emphasis lsb", {7'b0, csBit}, 8'h01);

    // R6 / R7 full block walk and wrap
    blk();
    for (int f = 0; f < 192; f++) begin
      chk("R6 frame bit", {7'b0, csBit}, {7'b0, expBit(expFrame)});
      strobe();
    end
    chk("R7 wrap to frame 0", {7'b0, csBit}, {7'b0, expBit(0)});
    // R7 restart mid-block
    repeat (10) strobe();
    chk("R6 frame 10", {7'b0, csBit}, {7'b0, expBit(10)});
    blk();
    chk("R7 restart", {7'b0, csBit}, {7'b0, expBit(0)});

    // R5 working write in the committing cycle is taken
    wr(4'd0, 8'h01);
    regAddr = 4'd3; regWrData = 8'h3E; regWrEn = 1'b1; blockStart = 1'b1;
    tick();
    regWrEn = 1'b0; blockStart = 1'b0; expFrame = 0;
    expSh[2] = 8'h3E;
    shadowChk("R5 same-cycle write");
    rdChk("R5 clear", 4'd0, 8'h00);

    // R5 set on block start with nothing pending stays pending
    wr(4'd5, 8'h42);
    regAddr = 4'd0; regWrData = 8'h01; regWrEn = 1'b1; blockStart = 1'b1;
    tick();
    regWrEn = 1'b0; blockStart = 1'b0; expFrame = 0;
    rdChk("R5 set kept", 4'd0, 8'h01);
    shadowChk("R5 no early commit");
    blk();
    expSh[4] = 8'h42;
    shadowChk("R5 later commit");
    rdChk("R5 cleared", 4'd0, 8'h00);

    // R5 set on committing edge is absorbed
    wr(4'd0, 8'h01);
    regAddr = 4'd0; regWrData = 8'h01; regWrEn = 1'b1; blockStart = 1'b1;
    tick();
    regWrEn = 1'b0; blockStart = 1'b0; expFrame = 0;
    rdChk("R5 absorbed", 4'd0, 8'h00);
    wr(4'd1, 8'h00);
    blk();
    shadowChk("R5 no second commit");

    // R1 reset again mid-run
    rstN = 1'b0; tick(); tick();
    for (int a = 0; a < 16; a++) rdChk("R1 re-reset", 4'(a), 8'h00);
    chk("R1 csBit re-reset", {7'b0, csBit}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule